// File: doc/BRIEF.md
# Aliased SRAM Address Decoder

One on-chip SRAM can be reached through three address windows, each 16 MB wide by default. Each window carries its own access attribute. The window at 0x0400_0000 is the tightly-coupled data path, which only the CPU can use. The window at 0x4000_0000 is the buffered system-bus view. The window at 0x5000_0000 is the non-buffered system-bus view.

The decoder serves two requesters: the CPU and a second bus master such as a DMA engine. For each request it gives, in the same cycle, the following:
- the physical SRAM offset;
- a hit flag, or an error flag when the offset lies past the enabled memory size;
- the window that was matched;
- a write-buffer-enable attribute.

Only CPU writes into the buffered window are ever marked as buffered.

The enabled size is held in a small register that software can write. The register comes out of reset at the smallest size. A parameter caps the largest size that a given chip variant may select.

Top module: `sram_alias_decoder`

## Requirements
- R1: A CPU request whose address matches 0x0400_0000 on bits [31:24] and whose offset is in range gives hit=1, path=2'b01 (tightly-coupled), offset = address bits [16:0], and wbuf=0.
- R2: A request in the window 0x4000_0000 with the offset in range gives hit=1 and path=2'b10. For the CPU, wbuf=1 exactly when the access is a write.
- R3: A request in the window 0x5000_0000 with the offset in range gives hit=1, path=2'b11 and wbuf=0, for reads and writes alike.
- R4: After a synchronous reset the size register reads 2'b00, which enables 32 KB. Offset 0x7FFF then hits and offset 0x8000 returns an error.
- R5: The size code 2'b00 enables 32 KB, 2'b01 enables 64 KB and 2'b10 enables 96 KB. The code 2'b11 is stored and read back as written, but it enables 32 KB.
- R6: A size write that asks for more than the MAX_CODE parameter stores MAX_CODE. The reserved code 2'b11 is exempt from this and is stored as written.
- R7: The second master never gets wbuf=1 in any window. Its requests to the tightly-coupled window are not decoded, so hit=0, err=0 and path=2'b00.
- R8: An offset at or beyond the enabled size in a matched window gives err=1, hit=0 and offset=0, with path still naming the window.
- R9: An address outside all three windows, or a cycle with no request, gives hit=0, err=0, path=2'b00, wbuf=0 and offset=0.
- R10: The decode is combinational. Outputs follow the request inputs in the same cycle, and a size write takes effect from the next clock edge onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Size register write strobe |
| cfg_wdata | input | 2 | Requested size code |
| size_code | output | 2 | Stored size code (readback) |
| cpu_req | input | 1 | CPU request valid |
| cpu_addr | input | 32 | CPU byte address |
| cpu_write | input | 1 | CPU access is a write |
| cpu_hit | output | 1 | CPU access maps to SRAM |
| cpu_err | output | 1 | CPU access past the enabled size |
| cpu_path | output | 2 | CPU matched window: 00 none, 01 tightly-coupled, 10 buffered, 11 non-buffered |
| cpu_wbuf | output | 1 | CPU write may be buffered |
| cpu_offset | output | 17 | CPU physical SRAM offset |
| dma_req | input | 1 | Second master request valid |
| dma_addr | input | 32 | Second master byte address |
| dma_write | input | 1 | Second master access is a write |
| dma_hit | output | 1 | Second master access maps to SRAM |
| dma_err | output | 1 | Second master access past the enabled size |
| dma_path | output | 2 | Second master matched window (same encoding as cpu_path) |
| dma_wbuf | output | 1 | Second master buffered attribute |
| dma_offset | output | 17 | Second master physical SRAM offset |

## Verification
The bench probes the size boundary from both sides at every size code. A decoder with an off-by-one limit would hit on the first byte past the end, or would fault on the last valid byte. It also sends writes from the second master into the buffered window. A decoder that keyed the attribute on the window alone would raise wbuf there. Further cases cover the reserved code 2'b11 and requests above the cap, which a careless register would read as 128 KB or fail to clamp. A second instance built with a lower cap checks that clamping follows the parameter rather than a fixed value.

// File: rtl/sram_alias_pkg.sv
package sram_alias_pkg;
  localparam int ADDR_W = 32;

  typedef enum logic [1:0] {
    PATH_NONE = 2'b00,
    PATH_TCM  = 2'b01,
    PATH_BUF  = 2'b10,
    PATH_NBUF = 2'b11
  } path_e;

  localparam logic [ADDR_W-1:0] BASE_TCM  = 32'h0400_0000;
  localparam logic [ADDR_W-1:0] BASE_BUF  = 32'h4000_0000;
  localparam logic [ADDR_W-1:0] BASE_NBUF = 32'h5000_0000;
  localparam logic [1:0] CODE_RSVD = 2'b11;
endpackage

// File: rtl/sram_alias_size_reg.sv
module sram_alias_size_reg #(
  parameter int UNIT_LOG2 = 15,
  parameter int MAX_CODE  = 2,
  localparam int OFF_W    = UNIT_LOG2 + 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [1:0]       wdata,
  output logic [1:0]       code_q,
  output logic [OFF_W:0]   limit
);
  import sram_alias_pkg::*;

  localparam logic [1:0] CAP = 2'(MAX_CODE);

  logic [1:0] code_d;

  always_comb begin
    code_d = wdata;
    if (wdata != CODE_RSVD && wdata > CAP) code_d = CAP;
  end

  always_ff @(posedge clk) begin
    if (rst)     code_q <= 2'b00;
    else if (we) code_q <= code_d;
  end

  // Size in bytes = (code + 1) units; the reserved code falls back to one unit.
  always_comb begin
    if (code_q == CODE_RSVD) limit = (OFF_W+1)'(1) << UNIT_LOG2;
    else                     limit = (OFF_W+1)'({1'b0, code_q} + 3'd1) << UNIT_LOG2;
  end
endmodule

// File: rtl/sram_alias_port_decode.sv
module sram_alias_port_decode #(
  parameter bit IS_CPU    = 1'b1,
  parameter int WIN_AW    = 24,
  parameter int UNIT_LOG2 = 15,
  localparam int OFF_W    = UNIT_LOG2 + 2
) (
  input  logic                               req,
  input  logic [sram_alias_pkg::ADDR_W-1:0]  addr,
  input  logic                               write,
  input  logic [OFF_W:0]                     limit,
  output logic                               hit,
  output logic                               err,
  output logic [1:0]                         path,
  output logic                               wbuf,
  output logic [OFF_W-1:0]                   offset
);
  import sram_alias_pkg::*;

  localparam int TAG_W = ADDR_W - WIN_AW;

  logic [TAG_W-1:0]  tag;
  logic [WIN_AW-1:0] win_off;
  logic              in_range;
  path_e             win;

  assign tag      = addr[ADDR_W-1:WIN_AW];
  assign win_off  = addr[WIN_AW-1:0];
  assign in_range = (WIN_AW > OFF_W) ? (win_off < WIN_AW'(limit))
                                     : ((OFF_W+1)'(win_off) < limit);

  generate
    if (IS_CPU) begin : g_cpu_win
      always_comb begin
        if      (tag == BASE_TCM[ADDR_W-1:WIN_AW])  win = PATH_TCM;
        else if (tag == BASE_BUF[ADDR_W-1:WIN_AW])  win = PATH_BUF;
        else if (tag == BASE_NBUF[ADDR_W-1:WIN_AW]) win = PATH_NBUF;
        else                                        win = PATH_NONE;
      end
    end else begin : g_bus_win
      always_comb begin
        if      (tag == BASE_BUF[ADDR_W-1:WIN_AW])  win = PATH_BUF;
        else if (tag == BASE_NBUF[ADDR_W-1:WIN_AW]) win = PATH_NBUF;
        else                                        win = PATH_NONE;
      end
    end
  endgenerate

  logic matched;
  assign matched = req && (win != PATH_NONE);

  always_comb begin
    hit    = matched && in_range;
    err    = matched && !in_range;
    path   = matched ? win : PATH_NONE;
    offset = hit ? win_off[OFF_W-1:0] : '0;
  end

  generate
    if (IS_CPU) begin : g_cpu_buf
      assign wbuf = hit && write && (win == PATH_BUF);
    end else begin : g_bus_buf
      assign wbuf = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/sram_alias_decoder.sv
module sram_alias_decoder #(
  parameter int WIN_AW    = 24,
  parameter int UNIT_LOG2 = 15,
  parameter int MAX_CODE  = 2,
  localparam int OFF_W    = UNIT_LOG2 + 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_wdata,
  output logic [1:0]       size_code,
  input  logic             cpu_req,
  input  logic [31:0]      cpu_addr,
  input  logic             cpu_write,
  output logic             cpu_hit,
  output logic             cpu_err,
  output logic [1:0]       cpu_path,
  output logic             cpu_wbuf,
  output logic [OFF_W-1:0] cpu_offset,
  input  logic             dma_req,
  input  logic [31:0]      dma_addr,
  input  logic             dma_write,
  output logic             dma_hit,
  output logic             dma_err,
  output logic [1:0]       dma_path,
  output logic             dma_wbuf,
  output logic [OFF_W-1:0] dma_offset
);
  logic [OFF_W:0] limit;

  sram_alias_size_reg #(.UNIT_LOG2(UNIT_LOG2), .MAX_CODE(MAX_CODE)) size_i (
    .clk(clk), .rst(rst), .we(cfg_we), .wdata(cfg_wdata),
    .code_q(size_code), .limit(limit)
  );

  sram_alias_port_decode #(.IS_CPU(1'b1), .WIN_AW(WIN_AW), .UNIT_LOG2(UNIT_LOG2)) cpu_dec_i (
    .req(cpu_req), .addr(cpu_addr), .write(cpu_write), .limit(limit),
    .hit(cpu_hit), .err(cpu_err), .path(cpu_path), .wbuf(cpu_wbuf), .offset(cpu_offset)
  );

  sram_alias_port_decode #(.IS_CPU(1'b0), .WIN_AW(WIN_AW), .UNIT_LOG2(UNIT_LOG2)) dma_dec_i (
    .req(dma_req), .addr(dma_addr), .write(dma_write), .limit(limit),
    .hit(dma_hit), .err(dma_err), .path(dma_path), .wbuf(dma_wbuf), .offset(dma_offset)
  );
endmodule

// File: rtl/sram_alias_decoder_chk.sv
module sram_alias_decoder_chk #(
  parameter int UNIT_LOG2 = 15,
  parameter int MAX_CODE  = 2,
  localparam int OFF_W    = UNIT_LOG2 + 2
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_we,
  input logic [1:0]       cfg_wdata,
  input logic [1:0]       size_code,
  input logic             cpu_req,
  input logic [31:0]      cpu_addr,
  input logic             cpu_write,
  input logic             cpu_hit,
  input logic             cpu_err,
  input logic [1:0]       cpu_path,
  input logic             cpu_wbuf,
  input logic [OFF_W-1:0] cpu_offset,
  input logic             dma_req,
  input logic             dma_hit,
  input logic             dma_err,
  input logic [1:0]       dma_path,
  input logic             dma_wbuf
);
  logic [OFF_W+1:0] bytes_en;
  always_comb begin
    case (size_code)
      2'b01:   bytes_en = (OFF_W+2)'(2) << UNIT_LOG2;
      2'b10:   bytes_en = (OFF_W+2)'(3) << UNIT_LOG2;
      default: bytes_en = (OFF_W+2)'(1) << UNIT_LOG2;
    endcase
  end

  assert_reset_size_R4: assert property (@(posedge clk) $past(rst) |-> size_code == 2'b00);
  assert_clamp_R6: assert property (@(posedge clk) disable iff (rst)
    $past(cfg_we) && !$past(rst) |-> (size_code <= 2'(MAX_CODE) || size_code == 2'b11));
  assert_stable_size_R10: assert property (@(posedge clk) disable iff (rst)
    !$past(cfg_we) && !$past(rst) |-> $stable(size_code));
  assert_hit_in_size_R8: assert property (@(posedge clk) disable iff (rst)
    cpu_hit |-> (OFF_W+2)'(cpu_offset) < bytes_en);
  assert_excl_cpu_R8: assert property (@(posedge clk) disable iff (rst) !(cpu_hit && cpu_err));
  assert_excl_dma_R8: assert property (@(posedge clk) disable iff (rst) !(dma_hit && dma_err));
  assert_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !cpu_req |-> !cpu_hit && !cpu_err && cpu_path == 2'b00);
  assert_wbuf_cpu_R2: assert property (@(posedge clk) disable iff (rst)
    cpu_wbuf |-> cpu_write && cpu_hit && cpu_addr[31:28] == 4'h4);
  assert_dma_nobuf_R7: assert property (@(posedge clk) disable iff (rst)
    dma_req |-> !dma_wbuf && dma_path != 2'b01);
endmodule

bind sram_alias_decoder sram_alias_decoder_chk #(.UNIT_LOG2(UNIT_LOG2), .MAX_CODE(MAX_CODE)) chk_i (
  .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .size_code(size_code),
  .cpu_req(cpu_req), .cpu_addr(cpu_addr), .cpu_write(cpu_write),
  .cpu_hit(cpu_hit), .cpu_err(cpu_err), .cpu_path(cpu_path), .cpu_wbuf(cpu_wbuf),
  .cpu_offset(cpu_offset), .dma_req(dma_req), .dma_hit(dma_hit), .dma_err(dma_err),
  .dma_path(dma_path), .dma_wbuf(dma_wbuf)
);

// File: tb/sram_alias_decoder_tb_top.sv
module sram_alias_decoder_tb_top;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst, cfg_we;
  logic [1:0] cfg_wdata, size_code, size_code_b;
  logic cpu_req, cpu_write, dma_req, dma_write;
  logic [31:0] cpu_addr, dma_addr;
  logic cpu_hit, cpu_err, cpu_wbuf, dma_hit, dma_err, dma_wbuf;
  logic [1:0] cpu_path, dma_path;
  logic [16:0] cpu_offset, dma_offset;
  logic b_hit, b_err, b_wbuf, bd_hit, bd_err, bd_wbuf;
  logic [1:0] b_path, bd_path;
  logic [16:0] b_off, bd_off;

  int checks = 0;
  int fails  = 0;

  sram_alias_decoder dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .size_code(size_code),
    .cpu_req(cpu_req), .cpu_addr(cpu_addr), .cpu_write(cpu_write),
    .cpu_hit(cpu_hit), .cpu_err(cpu_err), .cpu_path(cpu_path), .cpu_wbuf(cpu_wbuf),
    .cpu_offset(cpu_offset), .dma_req(dma_req), .dma_addr(dma_addr), .dma_write(dma_write),
    .dma_hit(dma_hit), .dma_err(dma_err), .dma_path(dma_path), .dma_wbuf(dma_wbuf),
    .dma_offset(dma_offset)
  );

  sram_alias_decoder #(.MAX_CODE(1)) dut_cap_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .size_code(size_code_b),
    .cpu_req(cpu_req), .cpu_addr(cpu_addr), .cpu_write(cpu_write),
    .cpu_hit(b_hit), .cpu_err(b_err), .cpu_path(b_path), .cpu_wbuf(b_wbuf),
    .cpu_offset(b_off), .dma_req(dma_req), .dma_addr(dma_addr), .dma_write(dma_write),
    .dma_hit(bd_hit), .dma_err(bd_err), .dma_path(bd_path), .dma_wbuf(bd_wbuf),
    .dma_offset(bd_off)
  );

  // {is_dma, write, addr, hit, err, path, wbuf, offset}; size code 2'b10 (96 KB)
  localparam int NV = 10;
  localparam logic [55:0] VEC [NV] = '{
    {1'b0, 1'b0, 32'h0400_0010, 1'b1, 1'b0, 2'b01, 1'b0, 17'h00010}, // R1
    {1'b0, 1'b1, 32'h4001_7FFF, 1'b1, 1'b0, 2'b10, 1'b1, 17'h17FFF}, // R2
    {1'b0, 1'b0, 32'h4000_0100, 1'b1, 1'b0, 2'b10, 1'b0, 17'h00100}, // R2
    {1'b0, 1'b1, 32'h5000_2000, 1'b1, 1'b0, 2'b11, 1'b0, 17'h02000}, // R3
    {1'b0, 1'b1, 32'h4001_8000, 1'b0, 1'b1, 2'b10, 1'b0, 17'h00000}, // R8
    {1'b1, 1'b1, 32'h4000_0040, 1'b1, 1'b0, 2'b10, 1'b0, 17'h00040}, // R7
    {1'b1, 1'b1, 32'h5000_0040, 1'b1, 1'b0, 2'b11, 1'b0, 17'h00040}, // R7
    {1'b1, 1'b0, 32'h0400_0040, 1'b0, 1'b0, 2'b00, 1'b0, 17'h00000}, // R7
    {1'b0, 1'b0, 32'h2000_0000, 1'b0, 1'b0, 2'b00, 1'b0, 17'h00000}, // R9
    {1'b0, 1'b1, 32'h4100_0000, 1'b0, 1'b0, 2'b00, 1'b0, 17'h00000}  // R9
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cpu_go(input logic [31:0] a, input logic w);
    @(negedge clk);
    cpu_req = 1'b1; cpu_addr = a; cpu_write = w; dma_req = 1'b0;
    #1;
  endtask

  task automatic set_size(input logic [1:0] c);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = c;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  initial begin
    rst = 1'b1; cfg_we = 1'b0; cfg_wdata = 2'b00;
    cpu_req = 1'b0; cpu_addr = '0; cpu_write = 1'b0;
    dma_req = 1'b0; dma_addr = '0; dma_write = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R4 reset size", 32'(size_code), 32'h0);
    chk("R9 idle hit", 32'({cpu_hit, cpu_err, cpu_path}), 32'h0);

    cpu_go(32'h4000_7FFF, 1'b0); chk("R4 last 32K byte hit", 32'({cpu_hit, cpu_err}), 32'h2);
    cpu_go(32'h4000_8000, 1'b0); chk("R4 32K end err", 32'({cpu_hit, cpu_err}), 32'h1);

    set_size(2'b10);
    chk("R5 code 10 readback", 32'(size_code), 32'h2);
    for (int i = 0; i < NV; i++) begin
      logic [55:0] v;
      v = VEC[i];
      @(negedge clk);
      cpu_req = !v[55]; dma_req = v[55];
      cpu_addr = v[53:22]; dma_addr = v[53:22];
      cpu_write = v[54]; dma_write = v[54];
      #1;
      if (v[55]) chk($sformatf("R7 vec %0d", i),
                     {8'h0, dma_hit, dma_err, dma_path, dma_wbuf, dma_offset}, {8'h0, v[21:0], 2'b00} >> 2);
      else chk($sformatf("R1 R2 R3 R8 R9 vec %0d", i),
               {8'h0, cpu_hit, cpu_err, cpu_path, cpu_wbuf, cpu_offset}, {8'h0, v[21:0], 2'b00} >> 2);
    end

    set_size(2'b01);
    cpu_go(32'h5000_FFFF, 1'b1); chk("R5 64K last byte", 32'({cpu_hit, cpu_err}), 32'h2);
    cpu_go(32'h5001_0000, 1'b1); chk("R5 64K end err", 32'({cpu_hit, cpu_err}), 32'h1);

    set_size(2'b11);
    chk("R5 reserved readback", 32'(size_code), 32'h3);
    cpu_go(32'h0400_7FFF, 1'b0); chk("R5 reserved 32K hit", 32'({cpu_hit, cpu_err}), 32'h2);
    cpu_go(32'h0400_8000, 1'b0); chk("R5 reserved 32K err", 32'({cpu_hit, cpu_err}), 32'h1);

    set_size(2'b10);
    chk("R6 cap instance clamps", 32'(size_code_b), 32'h1);
    cpu_go(32'h4001_0000, 1'b0); chk("R6 cap instance err at 64K", 32'({b_hit, b_err}), 32'h1);
    chk("R10 same-cycle decode full", 32'({cpu_hit, cpu_offset}), 32'h30000);

    @(negedge clk);
    cpu_req = 1'b0; dma_req = 1'b1; dma_addr = 32'h4000_0000; dma_write = 1'b1;
    #1; chk("R7 dma write base no buffer", 32'({dma_hit, dma_wbuf}), 32'h2);
    chk("R9 cpu idle outputs", 32'({cpu_hit, cpu_err, cpu_path, cpu_wbuf, cpu_offset}), 32'h0);

    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0; #1;
    chk("R4 size after second reset", 32'(size_code), 32'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule